// File: doc/BRIEF.md
# Programmable loss-of-signal detector

This block watches a recovered receive bit stream, one bit per enabled receive-clock cycle, and keeps a loss-of-signal alarm. The alarm is raised when the line stays silent (no logical one) for a programmable number of bit periods, or at once when an analog front end reports that the signal level is too low. It is cleared only after a programmable number of received pulses (logical ones) have arrived while the level is normal.

The silence window is set by an 8-bit detection value scaled by 16, giving 16 to 4096 bit periods. The number of pulses needed to clear is set by a second 8-bit value. While the low-level flag is high, the data passed downstream is replaced by zeros, so that bit errors from a fading line do not reach later stages. A one-cycle event output marks every change of the alarm.

Top module: `los_monitor`

## Requirements
- R1: After reset the alarm output is 1, the change output is 0, the data output is 0, and both internal counts start from zero.
- R2: With the detection value D, the alarm is set on the clock edge that samples the ((D+1)×16)-th consecutive enabled zero bit; any enabled one bit restarts that count, so one bit fewer leaves the alarm clear.
- R3: In a cycle with the bit enable low and the low-level flag low, the bit input is ignored: it adds nothing to the silence count or the pulse count, and the data output keeps its value.
- R4: The alarm is set on the edge that samples the low-level flag high, whatever the silence count.
- R5: The data output takes the bit input on each enabled edge; on any edge that samples the low-level flag high it becomes 0, with or without the bit enable.
- R6: While the alarm is set and the low-level flag is low, each enabled one bit counts as a pulse; the alarm clears on the edge that samples the R-th such pulse, R being the recovery value, with a recovery value of 0 acting as 1.
- R7: One bits sampled while the low-level flag is high are not counted, and the pulse count returns to zero, so recovery counting starts only once the level is back to normal.
- R8: If a full silence window completes while pulses are being counted, the pulse count returns to zero and the alarm stays set.
- R9: The change output is 1 for exactly one cycle after each edge on which the alarm rises or falls, and 0 otherwise.
- R10: While the alarm is clear and the low-level flag is low, an enabled one bit keeps the alarm clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit enable: the bit input is valid in this cycle |
| rx_bit | input | 1 | Recovered receive bit, 1 means a pulse |
| low_level | input | 1 | Low signal level flag from the analog front end |
| det_cfg | input | 8 | Detection value D, window is (D+1)×16 bit periods |
| rec_cfg | input | 8 | Recovery value, pulses needed to clear (0 acts as 1) |
| los_alarm | output | 1 | Loss-of-signal alarm |
| los_change | output | 1 | One-cycle pulse on each alarm change |
| data_out | output | 1 | Registered receive data, forced to 0 under low level |

## Verification
The bench builds the block with its default widths, an 8-bit configuration and a scale of 16, so the full window range of 16 to 4096 bit periods is reached, including the longest window with one bit to spare. The shortest window of 16 lets silence runs interleave with pulse counts inside a few dozen cycles, which brings the window-during-recovery reset, the recovery value of 0 and pulses hidden under a low-level flag within reach. A random stretch with sparse enables and rare low-level flags is then compared cycle by cycle with a behavioural model.

// File: rtl/los_pkg.sv
// Package los_pkg
// Shared type for the loss-of-signal detector: the two states of the alarm.
// Assumes nothing beyond SystemVerilog enum support.
package los_pkg;

    typedef enum logic {
        LINE_OK   = 1'b0,
        LINE_LOST = 1'b1
    } los_state_t;

endpackage

// File: rtl/los_zero_run.sv
// Module los_zero_run
// Counts consecutive enabled zero bits and flags the edge that completes a
// silence window of (det_cfg + 1) << SCALE_LOG2 bits. The count restarts on
// an enabled one bit and after each completed window, so a longer silence
// completes the window again every window length.
// Assumes det_cfg is stable or changes only between silence runs.
module los_zero_run #(
    parameter int CFG_W      = 8,
    parameter int SCALE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic [CFG_W-1:0] det_cfg,
    output logic             window_hit
);
    localparam int RUN_W = CFG_W + SCALE_LOG2 + 1;

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_inc;
    logic [RUN_W-1:0] window_len;

    // Window length: (det_cfg + 1) scaled by 2**SCALE_LOG2.
    always_comb begin
        window_len = ({{(RUN_W-CFG_W){1'b0}}, det_cfg} + RUN_W'(1)) << SCALE_LOG2;
        run_inc    = run_q + RUN_W'(1);
        window_hit = bit_en && !rx_bit && (run_inc >= window_len);
    end

    // Silence counter: restart on a pulse or a completed window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (bit_en) begin
            if (rx_bit || window_hit) begin
                run_q <= '0;
            end else begin
                run_q <= run_inc;
            end
        end
    end

endmodule

// File: rtl/los_pulse_count.sv
// Module los_pulse_count
// Counts received pulses toward clearing the alarm. Reports done on the edge
// that brings the count to the recovery target; a recovery value of 0 acts
// as 1. A clear request has priority and empties the count.
// Assumes count_en and clr_req come from the alarm controller.
module los_pulse_count #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             clr_req,
    input  logic [CFG_W-1:0] rec_cfg,
    output logic             done
);
    localparam int CNT_W = CFG_W + 1;

    logic [CFG_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] target;

    // Target with 0 mapped to 1, and the count that this pulse would reach.
    always_comb begin
        target  = (rec_cfg == '0) ? CNT_W'(1) : {1'b0, rec_cfg};
        cnt_inc = {1'b0, cnt_q} + CNT_W'(1);
        done    = count_en && !clr_req && (cnt_inc >= target);
    end

    // Pulse counter: clear on request or completion, else count pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_req || done) begin
            cnt_q <= '0;
        end else if (count_en) begin
            cnt_q <= cnt_inc[CFG_W-1:0];
        end
    end

endmodule

// File: rtl/los_data_stage.sv
// Module los_data_stage
// Registers the receive bit on each enabled edge and substitutes a fixed
// fill level on any edge that samples the low-level flag high.
// Assumes FILL_BIT is the level downstream logic treats as no pulse.
module los_data_stage #(
    parameter logic FILL_BIT     = 1'b0,
    parameter bit   FILL_ON_IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic low_level,
    output logic data_out
);
    logic force_fill;

    // Select whether the fill is applied on edges without a valid bit too.
    generate
        if (FILL_ON_IDLE) begin : g_fill_any
            assign force_fill = low_level;
        end else begin : g_fill_enabled
            assign force_fill = low_level && bit_en;
        end
    endgenerate

    // Output register: fill under low level, else capture enabled bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= FILL_BIT;
        end else if (force_fill) begin
            data_out <= FILL_BIT;
        end else if (bit_en) begin
            data_out <= rx_bit;
        end
    end

endmodule

// File: rtl/los_monitor.sv
// Module los_monitor (top)
// Loss-of-signal detector: raises the alarm on a full silence window or a
// low-level flag, and clears it after the programmed number of pulses
// received at normal level. Emits a one-cycle change event and a data output
// that is zero-filled under low level.
// Assumes all inputs are synchronous to clk and reset is synchronous, active low.
module los_monitor #(
    parameter int CFG_W      = 8,
    parameter int SCALE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic             low_level,
    input  logic [CFG_W-1:0] det_cfg,
    input  logic [CFG_W-1:0] rec_cfg,
    output logic             los_alarm,
    output logic             los_change,
    output logic             data_out
);
    import los_pkg::*;

    los_state_t state_q;
    los_state_t state_d;
    logic       window_hit;
    logic       pulse_en;
    logic       pulse_clr;
    logic       pulse_done;

    los_zero_run #(
        .CFG_W      (CFG_W),
        .SCALE_LOG2 (SCALE_LOG2)
    ) u_zero_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .rx_bit     (rx_bit),
        .det_cfg    (det_cfg),
        .window_hit (window_hit)
    );

    // Pulses count only in alarm at normal level; anything else empties the count.
    always_comb begin
        pulse_en  = (state_q == LINE_LOST) && !low_level && bit_en && rx_bit;
        pulse_clr = (state_q == LINE_OK) || low_level || window_hit;
    end

    los_pulse_count #(
        .CFG_W    (CFG_W)
    ) u_pulse_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (pulse_en),
        .clr_req  (pulse_clr),
        .rec_cfg  (rec_cfg),
        .done     (pulse_done)
    );

    // Alarm next state: enter on silence or low level, leave on enough pulses.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_OK:   if (low_level || window_hit) state_d = LINE_LOST;
            LINE_LOST: if (pulse_done)              state_d = LINE_OK;
            default:                                state_d = LINE_LOST;
        endcase
    end

    // Alarm state and change event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= LINE_LOST;
            los_change <= 1'b0;
        end else begin
            state_q    <= state_d;
            los_change <= (state_d != state_q);
        end
    end

    assign los_alarm = (state_q == LINE_LOST);

    los_data_stage #(
        .FILL_BIT     (1'b0),
        .FILL_ON_IDLE (1'b1)
    ) u_data_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .rx_bit    (rx_bit),
        .low_level (low_level),
        .data_out  (data_out)
    );

endmodule

// File: rtl/los_monitor_checker.sv
// Module los_monitor_checker
// Port-level properties of the loss-of-signal detector, bound to los_monitor.
module los_monitor_checker #(
    parameter int CFG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             rx_bit,
    input logic             low_level,
    input logic [CFG_W-1:0] det_cfg,
    input logic [CFG_W-1:0] rec_cfg,
    input logic             los_alarm,
    input logic             los_change,
    input logic             data_out
);
    logic unused_cfg;
    assign unused_cfg = ^{det_cfg, rec_cfg};

    assert_low_sets_alarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        low_level |=> los_alarm);

    assert_low_fills_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        low_level |=> !data_out);

    assert_idle_holds_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !low_level) |=> $stable(data_out));

    assert_pulse_keeps_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!los_alarm && !low_level && bit_en && rx_bit) |=> !los_alarm);

    assert_change_marks_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        los_change |-> (los_alarm != $past(los_alarm)));

    assert_toggle_raises_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (los_alarm != $past(los_alarm)) |-> los_change);

    assert_idle_keeps_alarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !low_level) |=> $stable(los_alarm));

endmodule

bind los_monitor los_monitor_checker #(.CFG_W(CFG_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .rx_bit     (rx_bit),
    .low_level  (low_level),
    .det_cfg    (det_cfg),
    .rec_cfg    (rec_cfg),
    .los_alarm  (los_alarm),
    .los_change (los_change),
    .data_out   (data_out)
);

// File: tb/tb_los_monitor.sv
// Bench for los_monitor: directed scenarios plus a random stretch, with a
// behavioural reference model compared on every clock.
module tb_los_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b0;
    logic       low_level = 1'b0;
    logic [7:0] det_cfg = 8'd0;
    logic [7:0] rec_cfg = 8'd1;
    logic       los_alarm;
    logic       los_change;
    logic       data_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    // Reference model state
    int m_run = 0;
    int m_cnt = 0;
    bit m_alarm = 1'b1;
    bit m_chg = 1'b0;
    bit m_data = 1'b0;

    always #2 clk = ~clk;

    los_monitor dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .rx_bit     (rx_bit),
        .low_level  (low_level),
        .det_cfg    (det_cfg),
        .rec_cfg    (rec_cfg),
        .los_alarm  (los_alarm),
        .los_change (los_change),
        .data_out   (data_out)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model, updated on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        int win;
        int tgt;
        bit hit;
        bit cnt_go;
        bit finish;
        bit nxt;
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_alarm = 1'b1; m_chg = 1'b0; m_data = 1'b0;
        end else begin
            win = (int'(det_cfg) + 1) * 16;
            tgt = (rec_cfg == 0) ? 1 : int'(rec_cfg);
            hit = bit_en && !rx_bit && (m_run + 1 >= win);
            cnt_go = m_alarm && !low_level && bit_en && rx_bit;
            finish = cnt_go && (m_cnt + 1 >= tgt);
            if (m_alarm) nxt = !finish;
            else         nxt = low_level || hit;
            if (!m_alarm || low_level || hit || finish) m_cnt = 0;
            else if (cnt_go) m_cnt = m_cnt + 1;
            if (bit_en) m_run = (rx_bit || hit) ? 0 : m_run + 1;
            m_chg = (nxt != m_alarm);
            m_alarm = nxt;
            if (low_level) m_data = 1'b0;
            else if (bit_en) m_data = rx_bit;
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk("R2 R4 R6 R7 R8 alarm vs model", los_alarm, m_alarm);
            chk("R9 change vs model", los_change, m_chg);
            chk("R5 data vs model", data_out, m_data);
        end
    end

    task automatic finish_run();
        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cycles);
            finish_run();
        end
    end

    task automatic step(input logic b, input logic en, input logic low);
        rx_bit = b; bit_en = en; low_level = low;
        @(posedge clk);
        #1;
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0);
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset alarm", los_alarm, 1'b1);
        chk("R1 reset change", los_change, 1'b0);
        chk("R1 reset data", data_out, 1'b0);
        rst_n = 1'b1;
        det_cfg = 8'd0;
        rec_cfg = 8'd3;
        step(1'b0, 1'b0, 1'b0);
        chk("R1 alarm after reset release", los_alarm, 1'b1);

        // Recovery from reset with three pulses
        ones(2);
        chk("R6 two of three pulses", los_alarm, 1'b1);
        ones(1);
        chk("R6 third pulse clears", los_alarm, 1'b0);
        chk("R9 change on clear", los_change, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        chk("R9 change lasts one cycle", los_change, 1'b0);

        // Silence window of 16
        zeros(15);
        chk("R2 fifteen zeros", los_alarm, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        chk("R10 pulse keeps clear", los_alarm, 1'b0);
        zeros(15);
        chk("R2 restart after pulse", los_alarm, 1'b0);
        zeros(1);
        chk("R2 sixteenth zero", los_alarm, 1'b1);
        chk("R9 change on assert", los_change, 1'b1);

        // Ignored idle cycles
        rec_cfg = 8'd1;
        ones(1);
        chk("R6 single pulse clears", los_alarm, 1'b0);
        chk("R5 data takes one", data_out, 1'b1);
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 1'b0);
        chk("R3 idle keeps data", data_out, 1'b1);
        chk("R3 idle adds no silence", los_alarm, 1'b0);
        zeros(15);
        chk("R3 window still needs 16", los_alarm, 1'b0);
        zeros(1);
        chk("R2 window after idle", los_alarm, 1'b1);

        // Window during recovery
        rec_cfg = 8'd4;
        ones(3);
        zeros(16);
        ones(3);
        chk("R8 count reset by window", los_alarm, 1'b1);
        ones(1);
        chk("R6 fourth pulse clears", los_alarm, 1'b0);

        // Low level
        rec_cfg = 8'd2;
        step(1'b1, 1'b1, 1'b1);
        chk("R4 low level sets alarm", los_alarm, 1'b1);
        chk("R5 low level fills zero", data_out, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1);
        chk("R7 pulses under low ignored", los_alarm, 1'b1);
        step(1'b1, 1'b1, 1'b0);
        chk("R7 first pulse after level back", los_alarm, 1'b1);
        ones(1);
        chk("R6 second pulse clears", los_alarm, 1'b0);
        rec_cfg = 8'd0;
        step(1'b1, 1'b0, 1'b1);
        chk("R5 fill without enable", data_out, 1'b0);
        chk("R4 alarm without enable", los_alarm, 1'b1);
        ones(1);
        chk("R6 recovery value 0 acts as 1", los_alarm, 1'b0);

        // Longest window
        det_cfg = 8'd255;
        zeros(4095);
        chk("R2 4095 zeros", los_alarm, 1'b0);
        zeros(1);
        chk("R2 4096th zero", los_alarm, 1'b1);

        // Random stretch against the model
        det_cfg = 8'd1;
        rec_cfg = 8'd3;
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            step((r < 15) ? 1'b1 : 1'b0, ($urandom_range(0, 3) != 0), (r > 97));
            if (i == 2000) rec_cfg = 8'd0;
        end

        step(1'b0, 1'b0, 1'b0);
        finish_run();
    end

endmodule